// File: doc/BRIEF.md
# Correlation-Programmable Stochastic Bit-Stream Pair Source

This block turns two 8-bit binary levels into a pair of stochastic bit-streams whose mutual correlation is set at run time. Each clock cycle it emits one bit of stream X and one bit of stream Y. The long-run density of 1s in a stream equals its level divided by 2^W. Three free-running maximal-length LFSRs supply the random numbers. X is always compared against the first LFSR. The random number fed to Y's comparator is chosen afresh every cycle by a four-way selector.

The selector is driven by a sign bit and a magnitude. A third LFSR, bit-reversed, is compared against the magnitude. When it falls below the magnitude, Y uses a correlated source: the first LFSR itself for positive sign, or its bitwise complement for negative sign. Otherwise Y uses the independent second LFSR. The selector has no held state. It has four named picks, coded as {sign, correlated}: PICK_INDEP_P (00), PICK_SAME (01), PICK_INDEP_N (10) and PICK_INV (11). It moves between them freely from one cycle to the next, as the pick comparison dictates. A magnitude of 256 or more forces the correlated pick on every cycle, and 0 forbids it on every cycle. Downstream stochastic arithmetic uses the two streams with positive, negative or zero correlation, for example an AND gate as a minimum or an XOR gate as an absolute difference.

Top module: `scc_pair_gen`

## Requirements
- R1: While rst_n is low, x_bit and y_bit are 0. The three sources load their seeds: main 0xA5, alternate 0x3C, pick 0xE1.
- R2: Each source is an 8-bit Fibonacci LFSR that advances on every clock edge after reset. The next state is {s[6:0], s[7]^s[5]^s[4]^s[3]}. On the edge that moves the main source from state r1, x_bit takes the value (r1 < nx).
- R3: With corr_neg = 0 and corr_mag >= 256, Y compares against the same main-source number as X, so y_bit equals (r1 < ny). When nx equals ny, x_bit equals y_bit on every cycle.
- R4: With corr_mag = 0, Y compares against the alternate source r2, so y_bit = (r2 < ny) whatever corr_neg is.
- R5: With corr_neg = 1 and corr_mag >= 256, Y compares against ~r1, so y_bit = (~r1 < ny). When nx + ny <= 256, x_bit and y_bit are never both 1.
- R6: For any corr_mag, let p be the pick source's state with its bits reversed (bit i taken from bit 7-i). A cycle uses the correlated number when p < corr_mag, and the alternate source otherwise.
- R7: A level of 0 yields a stream that stays at 0.
- R8: The sources never reach the all-zero state. The main source visits each of the 255 non-zero values once per 255 cycles, so a level of 128 gives exactly 127 ones per period.
- R9: A corr_mag above 256, up to 511, behaves exactly as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nx | input | 8 | Level for stream X |
| ny | input | 8 | Level for stream Y |
| corr_neg | input | 1 | Correlation sign, 1 = negative |
| corr_mag | input | 9 | Correlation magnitude in units of 1/256 |
| x_bit | output | 1 | Stream X, registered |
| y_bit | output | 1 | Stream Y, registered |

## Verification
The pick comparison and the sign handling act in the same cycle. A single Y bit depends on whether the bit-reversed pick source falls below the magnitude and also on which polarity of the main source is then routed to the comparator. The random phase holds sign, magnitude and both levels constant over stretches of cycles and re-draws them at random. This makes correlated and independent picks of both signs land on neighbouring cycles. Every bit is judged against a bench model that applies the requirement's selection rule to its own copies of the three sources.

// File: rtl/scc_pair_pkg.sv
package scc_pair_pkg;

    // Source routed to Y's comparator, coded as {sign, correlated}
    typedef enum logic [1:0] {
        PICK_INDEP_P = 2'b00,
        PICK_SAME    = 2'b01,
        PICK_INDEP_N = 2'b10,
        PICK_INV     = 2'b11
    } pick_e;

    localparam int unsigned NUM_SOURCES = 3;

endpackage

// File: rtl/scc_lfsr.sv
module scc_lfsr #(
    parameter int unsigned     W    = 8,
    parameter logic [W-1:0]    TAPS = 8'hB8,
    parameter logic [W-1:0]    SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);

    logic feedback;

    always_comb begin
        feedback = ^(state & TAPS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= {state[W-2:0], feedback};
        end
    end

endmodule

// File: rtl/scc_source_mux.sv
module scc_source_mux
    import scc_pair_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] r_main,
    input  logic [W-1:0] r_alt,
    input  logic [W-1:0] r_pick,
    input  logic         corr_neg,
    input  logic [W:0]   corr_mag,
    output logic [W-1:0] y_rand
);

    logic  use_corr;
    pick_e pick;

    always_comb begin
        use_corr = ({1'b0, r_pick} < corr_mag);
        pick     = pick_e'({corr_neg, use_corr});
    end

    always_comb begin
        unique case (pick)
            PICK_SAME:    y_rand = r_main;
            PICK_INV:     y_rand = ~r_main;
            PICK_INDEP_P: y_rand = r_alt;
            PICK_INDEP_N: y_rand = r_alt;
            default:      y_rand = r_alt;
        endcase
    end

endmodule

// File: rtl/scc_threshold_cmp.sv
module scc_threshold_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] rnd,
    input  logic [W-1:0] level,
    output logic         hit
);

    always_comb begin
        hit = (rnd < level);
    end

endmodule

// File: rtl/scc_pair_gen.sv
module scc_pair_gen
    import scc_pair_pkg::*;
#(
    parameter int unsigned  W         = 8,
    parameter logic [W-1:0] TAPS      = 8'hB8,
    parameter logic [W-1:0] SEED_MAIN = 8'hA5,
    parameter logic [W-1:0] SEED_ALT  = 8'h3C,
    parameter logic [W-1:0] SEED_PICK = 8'hE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nx,
    input  logic [W-1:0] ny,
    input  logic         corr_neg,
    input  logic [W:0]   corr_mag,
    output logic         x_bit,
    output logic         y_bit
);

    logic [W-1:0] src_q [NUM_SOURCES];
    logic [W-1:0] r_main;
    logic [W-1:0] r_alt;
    logic [W-1:0] r_pick_raw;
    logic [W-1:0] r_pick;
    logic [W-1:0] y_rand;
    logic         x_next;
    logic         y_next;

    for (genvar g = 0; g < NUM_SOURCES; g++) begin : g_src
        localparam logic [W-1:0] SEED_G = (g == 0) ? SEED_MAIN :
                                          (g == 1) ? SEED_ALT  : SEED_PICK;
        scc_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED_G)) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .state (src_q[g])
        );
    end

    assign r_main     = src_q[0];
    assign r_alt      = src_q[1];
    assign r_pick_raw = src_q[2];

    for (genvar b = 0; b < W; b++) begin : g_rev
        assign r_pick[b] = r_pick_raw[W-1-b];
    end

    scc_source_mux #(.W(W)) u_mux (
        .r_main   (r_main),
        .r_alt    (r_alt),
        .r_pick   (r_pick),
        .corr_neg (corr_neg),
        .corr_mag (corr_mag),
        .y_rand   (y_rand)
    );

    scc_threshold_cmp #(.W(W)) u_cmp_x (
        .rnd   (r_main),
        .level (nx),
        .hit   (x_next)
    );

    scc_threshold_cmp #(.W(W)) u_cmp_y (
        .rnd   (y_rand),
        .level (ny),
        .hit   (y_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_bit <= 1'b0;
            y_bit <= 1'b0;
        end else begin
            x_bit <= x_next;
            y_bit <= y_next;
        end
    end

endmodule

// File: rtl/scc_pair_gen_chk.sv
module scc_pair_gen_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] nx,
    input logic [W-1:0] ny,
    input logic         corr_neg,
    input logic [W:0]   corr_mag,
    input logic         x_bit,
    input logic         y_bit,
    input logic [W-1:0] r_main,
    input logic [W-1:0] r_alt,
    input logic [W-1:0] r_pick_raw
);

    localparam logic [W:0] FULL = 1 << W;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!x_bit && !y_bit)
                else $error("outputs active in reset");
        end
    end

    p_x_follows_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (x_bit == ($past(r_main) < $past(nx))));

    p_same_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!corr_neg && corr_mag >= FULL && nx == ny))
        |-> (x_bit == y_bit));

    p_indep_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(corr_mag == '0))
        |-> (y_bit == ($past(r_alt) < $past(ny))));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(corr_neg && corr_mag >= FULL &&
                                ({1'b0, nx} + {1'b0, ny}) <= FULL))
        |-> !(x_bit && y_bit));

    p_zero_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(nx == '0)) |-> !x_bit);

    p_never_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_main != '0) && (r_alt != '0) && (r_pick_raw != '0));

endmodule

bind scc_pair_gen scc_pair_gen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nx         (nx),
    .ny         (ny),
    .corr_neg   (corr_neg),
    .corr_mag   (corr_mag),
    .x_bit      (x_bit),
    .y_bit      (y_bit),
    .r_main     (r_main),
    .r_alt      (r_alt),
    .r_pick_raw (r_pick_raw)
);

// File: tb/scc_pair_gen_tb.sv
`timescale 1ns/1ps
module scc_pair_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] nx = '0;
    logic [7:0] ny = '0;
    logic       corr_neg = 1'b0;
    logic [8:0] corr_mag = '0;
    logic       x_bit;
    logic       y_bit;

    int checks = 0;
    int errors = 0;
    logic [7:0] m1, m2, m3;
    logic       last_x, last_y;

    always #2.5 clk = ~clk;

    scc_pair_gen u_dut (
        .clk(clk), .rst_n(rst_n), .nx(nx), .ny(ny),
        .corr_neg(corr_neg), .corr_mag(corr_mag),
        .x_bit(x_bit), .y_bit(y_bit)
    );

    function automatic logic [7:0] adv(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] s);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = s[7-i];
        return r;
    endfunction

    function automatic logic [7:0] y_source(input logic [7:0] a, input logic [7:0] b,
                                            input logic [7:0] c, input logic neg,
                                            input logic [8:0] mag);
        if ({1'b0, rev8(c)} < mag) return neg ? ~a : a;
        return b;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, let one edge pass, compare at the next negedge
    task automatic step(input logic [7:0] a, input logic [7:0] b,
                        input logic neg, input logic [8:0] mag, input string tag);
        logic ex, ey;
        nx = a; ny = b; corr_neg = neg; corr_mag = mag;
        ex = (m1 < a);
        ey = (y_source(m1, m2, m3, neg, mag) < b);
        @(posedge clk);
        @(negedge clk);
        m1 = adv(m1); m2 = adv(m2); m3 = adv(m3);
        last_x = x_bit; last_y = y_bit;
        check(x_bit == ex, {tag, " x"}, x_bit, ex);
        check(y_bit == ey, {tag, " y"}, y_bit, ey);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ones;
        logic [7:0] a, b;
        logic neg;
        logic [8:0] mag;
        void'($urandom(32'd2024));
        m1 = 8'hA5; m2 = 8'h3C; m3 = 8'hE1;
        nx = 8'd200; ny = 8'd200; corr_mag = 9'd256;
        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            check(!x_bit && !y_bit, "R1 reset", {x_bit, y_bit}, 0);
        end
        rst_n = 1'b1;

        // R2 and R3: identical streams with equal levels, positive full correlation
        for (int i = 0; i < 300; i++) begin
            a = 8'($urandom);
            step(a, a, 1'b0, 9'd256, "R2 R3");
            check(last_x == last_y, "R3 same", last_y, last_x);
        end

        // R4: magnitude zero, both signs
        for (int i = 0; i < 300; i++)
            step(8'($urandom), 8'($urandom), 1'($urandom), 9'd0, "R4");

        // R5: inverted source, no overlap when levels sum to at most 256
        for (int i = 0; i < 300; i++) begin
            a = 8'($urandom_range(0, 255));
            b = 8'(255 - a);
            step(a, b, 1'b1, 9'd256, "R5");
            check(!(last_x && last_y), "R5 overlap", {last_x, last_y}, 0);
        end
        step(8'd100, 8'd156, 1'b1, 9'd256, "R5 edge");

        // R6: random magnitudes, held for short stretches
        for (int i = 0; i < 200; i++) begin
            a = 8'($urandom); b = 8'($urandom);
            neg = 1'($urandom); mag = 9'($urandom_range(1, 255));
            for (int j = 0; j < 10; j++) step(a, b, neg, mag, "R6");
        end
        step(8'd128, 8'd128, 1'b0, 9'd1, "R6 mag1");
        step(8'd128, 8'd128, 1'b1, 9'd255, "R6 mag255");

        // R7: zero levels
        for (int i = 0; i < 100; i++) begin
            step(8'd0, 8'd0, 1'($urandom), 9'($urandom), "R7");
            check(!last_x && !last_y, "R7 zero", {last_x, last_y}, 0);
        end

        // R9: oversized magnitudes behave as full
        for (int i = 0; i < 200; i++) begin
            a = 8'($urandom);
            step(a, a, 1'b0, 9'($urandom_range(257, 511)), "R9");
            check(last_x == last_y, "R9 same", last_y, last_x);
        end

        // R8: one full period at level 128 gives 127 ones
        ones = 0;
        for (int i = 0; i < 255; i++) begin
            step(8'd128, 8'd128, 1'b0, 9'd256, "R8");
            ones += int'(last_x);
        end
        check(ones == 127, "R8 period count", ones, 127);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule